// File: doc/BRIEF.md
# LDPC Min-Sum Iterative Decoder

This block decodes a small regular low-density parity-check code by exchanging messages along the edges of its Tanner graph. It alternates two phases. In the variable-node phase, each bit adds its channel value to the check replies it has received. In the check-node phase, each parity check runs a min-sum update. Every reply on an edge leaves out what arrived on that same edge. Edge messages sit in two register banks. The variable phase reads the reply bank and writes the query bank; the check phase reads the query bank and writes the reply bank. The two banks therefore swap read and write roles on every phase.

The code is an array code over a prime `P` with `DV` slopes. It has `P*P` bits, `DV*P` checks, bit degree `DV` and check degree `P`. Two bits never share more than one check, so the graph has no cycles of length four. A caller places one signed soft value per bit on `llr_in`, sets an iteration limit and pulses `start`. After the last variable phase, `done` pulses for one cycle. At that point `hard_out` and `parity_ok` hold the result, and they keep it until the next accepted start.

Top module: `ldpc_minsum_decoder`

## Requirements
- R1: After reset, `done`, `parity_ok` and every bit of `hard_out` are 0.
- R2: The variable-node message on edge (bit n, slope s) equals the channel value of n plus the replies on the other `DV-1` edges of n. It is saturated to the symmetric range [-(2^(W-1)-1), +(2^(W-1)-1)], which is ±31 for W=6.
- R3: The check-node reply on each edge takes as its sign the XOR of the signs of the check's other incoming messages, where a negative value counts as sign 1. Its magnitude is the smallest magnitude among those other messages.
- R4: Each hard decision is 1 exactly when the channel value plus all `DV` replies of that bit is negative. A sum of zero gives 0. With an iteration limit of 0, `hard_out` is therefore the sign of the channel values.
- R5: `parity_ok` is 1 exactly when every check is satisfied by the current `hard_out`. Decoding stops at the first variable phase whose decisions satisfy all checks.
- R6: When a run ends, `done` rises 1+2k clock edges after the edge that accepts `start`. Here k is the number of check phases executed, and k never exceeds the `max_iter` value captured at start.
- R7: A `start` pulse that arrives while a decode is in progress is ignored. The result is that of the run already under way.
- R8: Soft values are W-bit two's complement. A channel value of -2^(W-1) is clamped to -(2^(W-1)-1) when it is captured.
- R9: Bit (a,b) has index n=a*P+b, and its channel value sits at `llr_in[n*W +: W]`. Check (s,c), for slope s in 0..DV-1 and offset c in 0..P-1, covers the bits (a, (c+s*a) mod P) for a in 0..P-1.
- R10: `done` is high for exactly one cycle. `hard_out` and `parity_ok` then stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a decode when the block is idle |
| max_iter | input | ITW | Maximum number of check phases, captured at start |
| llr_in | input | P*P*W | Channel soft values, one W-bit field per bit, positive meaning 0 |
| hard_out | output | P*P | Hard decisions of the last variable phase |
| parity_ok | output | 1 | All checks satisfied by `hard_out` |
| done | output | 1 | One-cycle pulse at the end of a decode |

## Verification
Three kinds of internal fault show up at the ports in different ways. A wrong edge index, a bad exclusion or a bad minimum corrupts the messages, and this usually shows after one or two iterations: `hard_out` differs from an independent min-sum model, or the `done` latency of 1+2k changes because convergence comes at another iteration. A fault in the syndrome path shows at once as a wrong `parity_ok`, even with the limit set to 0. A bank that is never cleared or is captured late corrupts the first result that follows a previous decode.

// File: rtl/ldpc_pkg.sv
package ldpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIT  = 2'd1,
    ST_CHK  = 2'd2
  } dec_state_t;

  // clip to symmetric range [-lim, +lim]
  function automatic int sat_val(input int v, input int lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic int abs_val(input int v);
    return (v < 0) ? -v : v;
  endfunction

endpackage

// File: rtl/ldpc_bit_stage.sv
module ldpc_bit_stage import ldpc_pkg::*; #(
  parameter int P  = 5,
  parameter int DV = 3,
  parameter int W  = 6
) (
  input  logic [P*P*W-1:0]    ch_flat,
  input  logic [DV*P*P*W-1:0] rep_flat,
  output logic [DV*P*P*W-1:0] qry_flat,
  output logic [P*P-1:0]      hd
);
  localparam int N   = P * P;
  localparam int LIM = (1 << (W - 1)) - 1;

  for (genvar n = 0; n < N; n++) begin : g_var
    int total;
    always_comb begin
      total = int'($signed(ch_flat[n*W +: W]));
      for (int s = 0; s < DV; s++)
        total += int'($signed(rep_flat[(s*N+n)*W +: W]));
    end
    assign hd[n] = (total < 0);
    for (genvar s = 0; s < DV; s++) begin : g_edge
      assign qry_flat[(s*N+n)*W +: W] =
        W'(sat_val(total - int'($signed(rep_flat[(s*N+n)*W +: W])), LIM));
    end
  end

endmodule

// File: rtl/ldpc_check_stage.sv
module ldpc_check_stage import ldpc_pkg::*; #(
  parameter int P  = 5,
  parameter int DV = 3,
  parameter int W  = 6
) (
  input  logic [DV*P*P*W-1:0] qry_flat,
  input  logic [P*P-1:0]      hd,
  output logic [DV*P*P*W-1:0] rep_flat,
  output logic [DV*P-1:0]     syn
);
  localparam int N   = P * P;
  localparam int LIM = (1 << (W - 1)) - 1;

  for (genvar s = 0; s < DV; s++) begin : g_slope
    for (genvar c = 0; c < P; c++) begin : g_chk
      logic [W-1:0] q_loc [P];
      logic [W-1:0] r_loc [P];
      logic [P-1:0] hd_loc;
      int           min1, min2, min_ix;
      logic         sgn_all;

      for (genvar a = 0; a < P; a++) begin : g_port
        localparam int BIT_IX  = a * P + ((c + s * a) % P);
        localparam int EDGE_IX = s * N + BIT_IX;
        assign q_loc[a]  = qry_flat[EDGE_IX*W +: W];
        assign hd_loc[a] = hd[BIT_IX];
        assign rep_flat[EDGE_IX*W +: W] = r_loc[a];
      end

      // keep smallest and second smallest magnitude
      always_comb begin
        min1    = LIM + 1;
        min2    = LIM + 1;
        min_ix  = 0;
        sgn_all = 1'b0;
        for (int a = 0; a < P; a++) begin
          sgn_all ^= q_loc[a][W-1];
          if (abs_val(int'($signed(q_loc[a]))) < min1) begin
            min2   = min1;
            min1   = abs_val(int'($signed(q_loc[a])));
            min_ix = a;
          end else if (abs_val(int'($signed(q_loc[a]))) < min2) begin
            min2 = abs_val(int'($signed(q_loc[a])));
          end
        end
        for (int a = 0; a < P; a++) begin
          int mag;
          mag = sat_val((a == min_ix) ? min2 : min1, LIM);
          r_loc[a] = (sgn_all ^ q_loc[a][W-1]) ? W'(-mag) : W'(mag);
        end
      end

      assign syn[s*P+c] = ^hd_loc;
    end
  end

endmodule

// File: rtl/ldpc_minsum_decoder.sv
module ldpc_minsum_decoder import ldpc_pkg::*; #(
  parameter int P   = 5,
  parameter int DV  = 3,
  parameter int W   = 6,
  parameter int ITW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ITW-1:0]       max_iter,
  input  logic [P*P*W-1:0]     llr_in,
  output logic [P*P-1:0]       hard_out,
  output logic                 parity_ok,
  output logic                 done
);
  localparam int N   = P * P;
  localparam int M   = DV * P;
  localparam int E   = DV * N;
  localparam int LIM = (1 << (W - 1)) - 1;

  dec_state_t      state;
  logic [N*W-1:0]  ch_bank, ch_d;
  logic [E*W-1:0]  qry_bank, rep_bank;
  logic [E*W-1:0]  qry_nx, rep_nx;
  logic [N-1:0]    hd_nx;
  logic [M-1:0]    syn;
  logic [ITW-1:0]  iter_cnt, iter_max;

  wire dec_busy = (state != ST_IDLE);
  wire par_nx   = ~|syn;
  wire last_bit = (state == ST_BIT) && (par_nx || iter_cnt == iter_max);

  for (genvar n = 0; n < N; n++) begin : g_clamp
    assign ch_d[n*W +: W] = W'(sat_val(int'($signed(llr_in[n*W +: W])), LIM));
  end

  ldpc_bit_stage #(.P(P), .DV(DV), .W(W)) bit_i (
    .ch_flat (ch_bank),
    .rep_flat(rep_bank),
    .qry_flat(qry_nx),
    .hd      (hd_nx)
  );

  ldpc_check_stage #(.P(P), .DV(DV), .W(W)) chk_i (
    .qry_flat(qry_bank),
    .hd      (hd_nx),
    .rep_flat(rep_nx),
    .syn     (syn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ch_bank   <= '0;
      qry_bank  <= '0;
      rep_bank  <= '0;
      iter_cnt  <= '0;
      iter_max  <= '0;
      hard_out  <= '0;
      parity_ok <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          ch_bank  <= ch_d;
          rep_bank <= '0;
          iter_cnt <= '0;
          iter_max <= max_iter;
          state    <= ST_BIT;
        end
        ST_BIT: begin
          qry_bank  <= qry_nx;
          hard_out  <= hd_nx;
          parity_ok <= par_nx;
          if (last_bit) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_CHK;
          end
        end
        ST_CHK: begin
          rep_bank <= rep_nx;
          iter_cnt <= iter_cnt + 1'b1;
          state    <= ST_BIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_cnt <= iter_max);

  // R6
  early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !parity_ok) |-> (iter_cnt == iter_max));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_busy && start) |=> $stable(ch_bank) && $stable(iter_max));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_busy) |=> $stable(hard_out) && $stable(parity_ok));

endmodule

// File: tb/ldpc_minsum_decoder_tb.sv
`timescale 1ns/1ps
module ldpc_minsum_decoder_tb_top;
  localparam int P   = 5;
  localparam int DV  = 3;
  localparam int W   = 6;
  localparam int ITW = 4;
  localparam int NB  = P * P;
  localparam int NE  = DV * NB;
  localparam int MX  = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ITW-1:0] max_iter = '0;
  logic [NB*W-1:0] llr_in = '0;
  logic [NB-1:0] hard_out;
  logic parity_ok, done;

  always #2.5 clk = ~clk;

  ldpc_minsum_decoder #(.P(P), .DV(DV), .W(W), .ITW(ITW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .max_iter(max_iter),
    .llr_in(llr_in), .hard_out(hard_out), .parity_ok(parity_ok), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int ch_in [NB];
  int ch_b  [NB];
  logic [NB-1:0] ref_hd;
  bit ref_par;
  int ref_k;
  int seed = 7;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nxt_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff_ffff;
  endfunction

  function automatic int chk_bit(input int s, input int c, input int a);
    return a * P + ((c + s * a) % P);
  endfunction

  function automatic int clip(input int v);
    return (v > MX) ? MX : ((v < -MX) ? -MX : v);
  endfunction

  // independent software min-sum model
  task automatic ref_decode(input int maxit);
    int rep [NE];
    int qry [NE];
    int chv [NB];
    foreach (rep[i]) rep[i] = 0;
    foreach (chv[i]) chv[i] = clip(ch_in[i]);
    ref_k = 0;
    while (1) begin
      for (int n = 0; n < NB; n++) begin
        int t;
        t = chv[n];
        for (int s = 0; s < DV; s++) t += rep[s*NB+n];
        ref_hd[n] = (t < 0);
        for (int s = 0; s < DV; s++) begin
          int o;
          o = chv[n];
          for (int u = 0; u < DV; u++) if (u != s) o += rep[u*NB+n];
          qry[s*NB+n] = clip(o);
        end
      end
      ref_par = 1'b1;
      for (int s = 0; s < DV; s++)
        for (int c = 0; c < P; c++) begin
          bit x;
          x = 1'b0;
          for (int a = 0; a < P; a++) x ^= ref_hd[chk_bit(s, c, a)];
          if (x) ref_par = 1'b0;
        end
      if (ref_par || ref_k == maxit) break;
      for (int s = 0; s < DV; s++)
        for (int c = 0; c < P; c++)
          for (int a = 0; a < P; a++) begin
            int mn, neg;
            mn = 1000; neg = 0;
            for (int b = 0; b < P; b++) if (b != a) begin
              int v;
              v = qry[s*NB + chk_bit(s, c, b)];
              if (v < 0) neg ^= 1;
              if ((v < 0 ? -v : v) < mn) mn = (v < 0 ? -v : v);
            end
            rep[s*NB + chk_bit(s, c, a)] = neg ? -mn : mn;
          end
      ref_k++;
    end
  endtask

  task automatic pack(input bit use_b);
    for (int n = 0; n < NB; n++)
      llr_in[n*W +: W] = use_b ? ch_b[n][W-1:0] : ch_in[n][W-1:0];
  endtask

  // inject_at > 0 pulses start with ch_b after that many cycles
  task automatic run_cmp(input int maxit, input int inject_at, input string req);
    int cyc;
    logic [NB-1:0] held;
    @(negedge clk);
    pack(1'b0);
    max_iter = ITW'(maxit);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (inject_at > 0 && cyc == inject_at) begin
        pack(1'b1);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done || cyc > 200) break;
    end
    start = 1'b0;
    ref_decode(maxit);
    check(hard_out == ref_hd, req, "hard_out", longint'(hard_out), longint'(ref_hd));
    check(parity_ok == ref_par, "R5", "parity_ok", longint'(parity_ok), longint'(ref_par));
    check(cyc == 1 + 2 * ref_k, "R6", "done latency", cyc, 1 + 2 * ref_k);
    held = hard_out;
    @(negedge clk);
    check(!done && hard_out == held, "R10", "done pulse and hold",
          longint'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done", longint'(done), 0);
    check(parity_ok == 1'b0, "R1", "parity_ok", longint'(parity_ok), 0);
    check(hard_out == '0, "R1", "hard_out", longint'(hard_out), 0);
    rst_n = 1'b1;

    // R4 R8: limit 0 gives channel signs, incl. zero and -32
    for (int t = 0; t < 30; t++) begin
      logic [NB-1:0] exp_hd;
      for (int n = 0; n < NB; n++) ch_in[n] = (nxt_rand() % 64) - 32;
      if (t == 0) begin ch_in[0] = 0; ch_in[1] = -32; ch_in[2] = 31; end
      for (int n = 0; n < NB; n++) exp_hd[n] = (ch_in[n] < 0);
      run_cmp(0, 0, "R4");
      check(hard_out == exp_hd, "R4", "sign of channel", longint'(hard_out), longint'(exp_hd));
    end

    // R5: clean all-zero codeword stops at once
    for (int n = 0; n < NB; n++) ch_in[n] = 10;
    run_cmp(8, 0, "R5");
    check(parity_ok == 1'b1, "R5", "clean codeword", longint'(parity_ok), 1);

    // R2 R3 R9: single flips on every bit of the zero codeword
    for (int f = 0; f < NB; f++) begin
      for (int n = 0; n < NB; n++) ch_in[n] = 8 + (n % 5);
      ch_in[f] = -6;
      run_cmp(8, 0, "R3");
      check(hard_out == '0, "R2", "single flip corrected", longint'(hard_out), 0);
    end

    // R8 R9: codeword with rows 0 and 1 set, double flips, saturating magnitudes
    for (int i = 0; i < NB; i++) begin
      int j;
      j = (i * 7 + 3) % NB;
      for (int n = 0; n < NB; n++) begin
        int mag;
        mag = (n % 3 == 0) ? 31 : 12 + n % 7;
        ch_in[n] = (n < 2 * P) ? -mag : mag;
      end
      ch_in[i] = -ch_in[i] / 3;
      if (j != i) ch_in[j] = (ch_in[j] < 0) ? 31 : -31;
      run_cmp(10, 0, "R8");
    end

    // R6: noisy patterns with a small limit
    for (int t = 0; t < 30; t++) begin
      for (int n = 0; n < NB; n++) ch_in[n] = (nxt_rand() % 40) - 12;
      run_cmp(3, 0, "R6");
    end

    // R7: start during a decode is ignored
    for (int n = 0; n < NB; n++) begin ch_in[n] = 9; ch_b[n] = -20; end
    ch_in[12] = -5;
    run_cmp(6, 2, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule